// File: doc/BRIEF.md
# Tile Prediction Error Evaluator

This block measures how well an external predictor models one square tile of 8-bit grayscale pixels. Pixels enter in raster order, one per accepted beat, and a tile-start flag marks the top-left pixel. For every pixel the block builds a causal context from four already-seen neighbours: the pixel above-left, the pixel above, the pixel above-right and the pixel to the left. It issues that context to a predictor port and lines up the returned guess with the true pixel value.

The absolute difference between the guess and the true value is added to a running tile error. Each of the four quadrants of the tile has its own threshold. A pixel whose difference is strictly above its quadrant's threshold becomes a transferred pixel, up to a configurable maximum. A transferred pixel adds nothing to the error, increments a counter and is emitted as a (position, original value) record. Once the maximum is used up, further over-threshold pixels are summed like any other pixel and raise a sticky flag. A one-cycle done pulse marks the point at which the tile totals are final.

Top module: `tile_pred_eval`

## Requirements
- R1: While reset is held and after it is released with no pixels, ctx_valid, xfer_valid and done are 0, and err_sum, xfer_count and limit_hit are 0.
- R2: Each accepted pixel (pix_valid high) produces ctx_valid high in the next cycle, and only then. That cycle carries the pixel's up-left, up, up-right and left neighbours in raster order within the tile.
- R3: Any neighbour that falls outside the tile (row 0, column 0 or column 15) is presented as 0.
- R4: A pixel accepted with pix_first high is position (0,0) of a new tile. The error sum, the transfer count and limit_hit restart from that pixel's result, with nothing carried over from the previous tile.
- R5: pred_data is taken exactly PRED_LAT cycles after the cycle in which its context was issued (default 2). The error of a pixel is |pred_data − original|.
- R6: The threshold for a pixel is thr_vec[8q+7:8q], where q = 2·row[3] + col[3] (0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right).
- R7: If the error is strictly greater than the threshold and the count is below xfer_limit, the pixel is transferred. xfer_valid goes high for one cycle, one cycle after the response, with xfer_pos = {row, col} (row in bits 7:4) and xfer_value = original pixel. The count rises by 1 and err_sum does not change.
- R8: An error equal to the threshold is not a transfer. It is added to err_sum.
- R9: Once the count has reached xfer_limit, an over-threshold pixel is not transferred. Its error is added to err_sum and limit_hit is set, and limit_hit stays set until the next tile restarts.
- R10: done is high for exactly one cycle, the cycle after the response for position 255. In that cycle err_sum, xfer_count and limit_hit show the tile's final values, and they hold until the next tile's first response.
- R11: err_sum is 16 bits wide and holds the largest possible tile error, 256 × 255 = 65280, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel beat valid |
| pix_first | input | 1 | Beat is position (0,0) of a new tile |
| pix_data | input | 8 | Original pixel value |
| thr_vec | input | 32 | Four 8-bit quadrant thresholds, quadrant q in bits 8q+7:8q |
| xfer_limit | input | 9 | Maximum number of transferred pixels per tile |
| ctx_valid | output | 1 | Context issued to the predictor |
| ctx_up_left | output | 8 | Neighbour above-left |
| ctx_up | output | 8 | Neighbour above |
| ctx_up_right | output | 8 | Neighbour above-right |
| ctx_left | output | 8 | Neighbour to the left |
| pred_data | input | 8 | Predictor response, PRED_LAT cycles after its context |
| xfer_valid | output | 1 | Transferred-pixel record valid |
| xfer_pos | output | 8 | Record position {row, col} |
| xfer_value | output | 8 | Record original value |
| done | output | 1 | One-cycle pulse: tile totals are final |
| err_sum | output | 16 | Accumulated absolute error of non-transferred pixels |
| xfer_count | output | 9 | Number of transferred pixels in the tile |
| limit_hit | output | 1 | An over-threshold pixel was refused for lack of budget |

## Verification
A transfer record and the done pulse can appear in the same cycle when the last pixel of a tile (position 255) is over its threshold. Also, the next tile's first response can reset the totals in the cycle right after done. The bench provokes both by streaming a tile whose final pixel is transferred directly behind a tile that ran out of transfer budget, with no idle beat between them. A scoreboard then requires the record, the final totals (including a cleared limit flag) and the restart to match its queued expectations in those exact cycles.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
    localparam int TILE_DIM = 16;
    localparam int PIX_W    = 8;
    localparam int COORD_W  = $clog2(TILE_DIM);
    localparam int POS_W    = 2 * COORD_W;
    localparam int NPIX     = TILE_DIM * TILE_DIM;
    localparam int CNT_W    = $clog2(NPIX + 1);
    localparam int SUM_W    = $clog2(NPIX * ((1 << PIX_W) - 1) + 1);
    localparam int NQUAD    = 4;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        pix_t ul;
        pix_t up;
        pix_t ur;
        pix_t lf;
    } ctx_t;

    typedef struct packed {
        logic vld;
        pos_t pos;
        pix_t orig;
    } tag_t;

    function automatic pix_t abs_diff(pix_t a, pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // quadrant index from the top bit of row and of column
    function automatic logic [1:0] quad_of(pos_t p);
        return {p[POS_W-1], p[COORD_W-1]};
    endfunction
endpackage

// File: rtl/tpe_context.sv
module tpe_context import tpe_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic pix_valid,
    input  logic pix_first,
    input  pix_t pix_data,
    output ctx_t ctx_q,
    output tag_t tag_q
);
    pix_t line_q [TILE_DIM];
    pix_t ul_q;
    pix_t left_q;
    pos_t pos_cnt;
    pos_t cur_pos;
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] col;
    logic [COORD_W-1:0] col_nx;
    ctx_t nxt;

    always_comb begin
        cur_pos = pix_first ? '0 : pos_cnt;
        row     = cur_pos[POS_W-1:COORD_W];
        col     = cur_pos[COORD_W-1:0];
        col_nx  = col + 1'b1;
        nxt.ul  = (row != '0 && col != '0) ? ul_q : '0;
        nxt.up  = (row != '0) ? line_q[col] : '0;
        nxt.ur  = (row != '0 && col != COORD_W'(TILE_DIM - 1)) ? line_q[col_nx] : '0;
        nxt.lf  = (col != '0) ? left_q : '0;
    end

    // previous row store; the overwritten entry moves to ul_q first
    always_ff @(posedge clk) begin
        if (pix_valid) line_q[col] <= pix_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_cnt <= '0;
            ul_q    <= '0;
            left_q  <= '0;
            ctx_q   <= '0;
            tag_q   <= '0;
        end else if (pix_valid) begin
            ctx_q   <= nxt;
            tag_q   <= '{vld: 1'b1, pos: cur_pos, orig: pix_data};
            ul_q    <= line_q[col];
            left_q  <= pix_data;
            pos_cnt <= cur_pos + 1'b1;
        end else begin
            tag_q.vld <= 1'b0;
        end
    end
endmodule

// File: rtl/tpe_delay.sv
module tpe_delay import tpe_pkg::*; #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  tag_t d,
    output tag_t q
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_pipe
            tag_t stg [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/tpe_accum.sv
module tpe_accum import tpe_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  tag_t                   cmp,
    input  pix_t                   pred,
    input  logic [NQUAD*PIX_W-1:0] thr_vec,
    input  logic [CNT_W-1:0]       limit,
    output logic [SUM_W-1:0]       sum_q,
    output logic [CNT_W-1:0]       cnt_q,
    output logic                   hit_q,
    output logic                   done_q,
    output logic                   xvld_q,
    output pos_t                   xpos_q,
    output pix_t                   xval_q
);
    pix_t             diff;
    pix_t             thr;
    logic [1:0]       quad;
    logic             over;
    logic             first;
    logic             take;
    logic [SUM_W-1:0] base_sum;
    logic [CNT_W-1:0] base_cnt;
    logic             base_hit;

    always_comb begin
        diff     = abs_diff(pred, cmp.orig);
        quad     = quad_of(cmp.pos);
        thr      = thr_vec[int'(quad) * PIX_W +: PIX_W];
        over     = diff > thr;
        first    = cmp.pos == '0;
        base_sum = first ? '0 : sum_q;
        base_cnt = first ? '0 : cnt_q;
        base_hit = first ? 1'b0 : hit_q;
        take     = over && (base_cnt < limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            cnt_q  <= '0;
            hit_q  <= 1'b0;
            done_q <= 1'b0;
            xvld_q <= 1'b0;
            xpos_q <= '0;
            xval_q <= '0;
        end else begin
            done_q <= cmp.vld && (cmp.pos == '1);
            xvld_q <= cmp.vld && take;
            if (cmp.vld) begin
                xpos_q <= cmp.pos;
                xval_q <= cmp.orig;
                if (take) begin
                    sum_q <= base_sum;
                    cnt_q <= base_cnt + 1'b1;
                    hit_q <= base_hit;
                end else begin
                    sum_q <= base_sum + SUM_W'(diff);
                    cnt_q <= base_cnt;
                    hit_q <= base_hit | over;
                end
            end
        end
    end
endmodule

// File: rtl/tile_pred_eval.sv
module tile_pred_eval import tpe_pkg::*; #(
    parameter int PRED_LAT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pix_valid,
    input  logic                   pix_first,
    input  logic [PIX_W-1:0]       pix_data,
    input  logic [NQUAD*PIX_W-1:0] thr_vec,
    input  logic [CNT_W-1:0]       xfer_limit,
    output logic                   ctx_valid,
    output logic [PIX_W-1:0]       ctx_up_left,
    output logic [PIX_W-1:0]       ctx_up,
    output logic [PIX_W-1:0]       ctx_up_right,
    output logic [PIX_W-1:0]       ctx_left,
    input  logic [PIX_W-1:0]       pred_data,
    output logic                   xfer_valid,
    output logic [POS_W-1:0]       xfer_pos,
    output logic [PIX_W-1:0]       xfer_value,
    output logic                   done,
    output logic [SUM_W-1:0]       err_sum,
    output logic [CNT_W-1:0]       xfer_count,
    output logic                   limit_hit
);
    ctx_t ctx;
    tag_t issue_tag;
    tag_t cmp_tag;

    tpe_context u_context (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_first (pix_first),
        .pix_data  (pix_data),
        .ctx_q     (ctx),
        .tag_q     (issue_tag)
    );

    assign ctx_valid    = issue_tag.vld;
    assign ctx_up_left  = ctx.ul;
    assign ctx_up       = ctx.up;
    assign ctx_up_right = ctx.ur;
    assign ctx_left     = ctx.lf;

    tpe_delay #(.DEPTH(PRED_LAT)) u_delay (
        .clk (clk),
        .rst (rst),
        .d   (issue_tag),
        .q   (cmp_tag)
    );

    tpe_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .cmp     (cmp_tag),
        .pred    (pred_data),
        .thr_vec (thr_vec),
        .limit   (xfer_limit),
        .sum_q   (err_sum),
        .cnt_q   (xfer_count),
        .hit_q   (limit_hit),
        .done_q  (done),
        .xvld_q  (xfer_valid),
        .xpos_q  (xfer_pos),
        .xval_q  (xfer_value)
    );
endmodule

// File: rtl/tile_pred_eval_chk.sv
module tile_pred_eval_chk import tpe_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             pix_valid,
    input logic             pix_first,
    input logic [CNT_W-1:0] xfer_limit,
    input logic             ctx_valid,
    input logic [PIX_W-1:0] ctx_up_left,
    input logic [PIX_W-1:0] ctx_up,
    input logic [PIX_W-1:0] ctx_up_right,
    input logic [PIX_W-1:0] ctx_left,
    input logic             xfer_valid,
    input logic [POS_W-1:0] xfer_pos,
    input logic             done,
    input logic [SUM_W-1:0] err_sum,
    input logic [CNT_W-1:0] xfer_count,
    input logic             limit_hit
);
    AST_CTX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> ctx_valid); // R2
    AST_CTX_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !ctx_valid); // R2
    AST_ORIGIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_first) |=> (ctx_up_left == '0 && ctx_up == '0 && ctx_up_right == '0 && ctx_left == '0)); // R3
    AST_XFER_IN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_count != '0 && xfer_count <= xfer_limit)); // R7
    AST_XFER_NO_SUM: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_pos != '0) |-> $stable(err_sum)); // R7
    AST_HIT_NO_XFER: assert property (@(posedge clk) disable iff (rst)
        limit_hit |-> !xfer_valid); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
endmodule

bind tile_pred_eval tile_pred_eval_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pix_valid    (pix_valid),
    .pix_first    (pix_first),
    .xfer_limit   (xfer_limit),
    .ctx_valid    (ctx_valid),
    .ctx_up_left  (ctx_up_left),
    .ctx_up       (ctx_up),
    .ctx_up_right (ctx_up_right),
    .ctx_left     (ctx_left),
    .xfer_valid   (xfer_valid),
    .xfer_pos     (xfer_pos),
    .done         (done),
    .err_sum      (err_sum),
    .xfer_count   (xfer_count),
    .limit_hit    (limit_hit)
);

// File: tb/tile_pred_eval_bench.sv
module tile_pred_eval_bench;
    localparam int LAT = 2;

    typedef struct packed {
        logic [15:0] sum;
        logic [8:0]  cnt;
        logic        hit;
    } res_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    always #2 clk = ~clk;

    logic        pix_valid = 1'b0;
    logic        pix_first = 1'b0;
    logic [7:0]  pix_data  = '0;
    logic [31:0] thr_vec   = '1;
    logic [8:0]  xfer_limit = 9'd256;
    logic        ctx_valid;
    logic [7:0]  ctx_up_left, ctx_up, ctx_up_right, ctx_left;
    logic [7:0]  pred_data;
    logic        xfer_valid;
    logic [7:0]  xfer_pos, xfer_value;
    logic        done;
    logic [15:0] err_sum;
    logic [8:0]  xfer_count;
    logic        limit_hit;

    int checks = 0;
    int errors = 0;
    int pmode = 0;
    logic [7:0] pconst = '0;
    logic [7:0] img [256];
    int unsigned seed = 32'd12345;

    logic [31:0] ctxq [$];
    logic [15:0] xq [$];
    res_t        resq [$];
    string       tagq [$];

    tile_pred_eval #(.PRED_LAT(LAT)) u_tile_pred_eval (
        .clk (clk), .rst (rst),
        .pix_valid (pix_valid), .pix_first (pix_first), .pix_data (pix_data),
        .thr_vec (thr_vec), .xfer_limit (xfer_limit),
        .ctx_valid (ctx_valid), .ctx_up_left (ctx_up_left), .ctx_up (ctx_up),
        .ctx_up_right (ctx_up_right), .ctx_left (ctx_left),
        .pred_data (pred_data),
        .xfer_valid (xfer_valid), .xfer_pos (xfer_pos), .xfer_value (xfer_value),
        .done (done), .err_sum (err_sum), .xfer_count (xfer_count), .limit_hit (limit_hit)
    );

    function automatic logic [7:0] pfun(logic [31:0] c);
        logic [7:0] t;
        t = (c[31:24] ^ c[23:16]) + (c[15:8] >> 1) + c[7:0];
        return (pmode == 1) ? pconst : t;
    endfunction

    // external predictor model with a two-cycle response
    logic [7:0] p1 = '0;
    logic [7:0] p2 = '0;
    always @(posedge clk) begin
        p1 <= pfun({ctx_up_left, ctx_up, ctx_up_right, ctx_left});
        p2 <= p1;
    end
    assign pred_data = p2;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic plan_tile(input string tag, output int exp_sum);
        int  sum = 0;
        int  cnt = 0;
        bit  hit = 1'b0;
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                logic [7:0] ul, up, ur, lf, pr, orig, d;
                int q;
                ul   = (r > 0 && c > 0)  ? img[(r-1)*16 + c - 1] : 8'd0;
                up   = (r > 0)           ? img[(r-1)*16 + c]     : 8'd0;
                ur   = (r > 0 && c < 15) ? img[(r-1)*16 + c + 1] : 8'd0;
                lf   = (c > 0)           ? img[r*16 + c - 1]     : 8'd0;
                orig = img[r*16 + c];
                pr   = pfun({ul, up, ur, lf});
                d    = (pr > orig) ? pr - orig : orig - pr;
                q    = (r >= 8 ? 2 : 0) + (c >= 8 ? 1 : 0);
                ctxq.push_back({ul, up, ur, lf});
                if (d > thr_vec[q*8 +: 8]) begin
                    if (cnt < int'(xfer_limit)) begin
                        cnt++;
                        xq.push_back({8'(r*16 + c), orig});
                    end else begin
                        sum += int'(d);
                        hit = 1'b1;
                    end
                end else begin
                    sum += int'(d);
                end
            end
        end
        resq.push_back('{sum: 16'(sum), cnt: 9'(cnt), hit: hit});
        tagq.push_back(tag);
        exp_sum = sum;
    endtask

    task automatic send_tile(input string tag, input bit gaps, input bit drain);
        int es;
        plan_tile(tag, es);
        for (int i = 0; i < 256; i++) begin
            if (gaps && (i % 7) == 3) begin
                @(negedge clk);
                pix_valid = 1'b0;
            end
            @(negedge clk);
            pix_valid = 1'b1;
            pix_first = (i == 0);
            pix_data  = img[i];
        end
        if (drain) begin
            @(negedge clk);
            pix_valid = 1'b0;
            pix_first = 1'b0;
            repeat (8) @(negedge clk);
            chk(err_sum == 16'(es), "R10", "err_sum held after done", err_sum, es);
        end
    endtask

    // monitor: compares design output against queued expectations
    always @(negedge clk) begin
        if (!rst) begin
            if (ctx_valid) begin
                if (ctxq.size() == 0) chk(1'b0, "R2", "unexpected context", 1, 0);
                else begin
                    logic [31:0] e;
                    e = ctxq.pop_front();
                    chk({ctx_up_left, ctx_up, ctx_up_right, ctx_left} == e, "R2 R3", "context",
                        {ctx_up_left, ctx_up, ctx_up_right, ctx_left}, e);
                end
            end
            if (xfer_valid) begin
                if (xq.size() == 0) chk(1'b0, "R7", "unexpected record", {xfer_pos, xfer_value}, 0);
                else begin
                    logic [15:0] e;
                    e = xq.pop_front();
                    chk({xfer_pos, xfer_value} == e, "R7", "record {pos,value}", {xfer_pos, xfer_value}, e);
                end
            end
            if (done) begin
                if (resq.size() == 0) chk(1'b0, "R10", "unexpected done", 1, 0);
                else begin
                    res_t  e;
                    string t;
                    e = resq.pop_front();
                    t = tagq.pop_front();
                    chk(err_sum == e.sum, t, "err_sum at done", err_sum, e.sum);
                    chk(xfer_count == e.cnt, t, "xfer_count at done", xfer_count, e.cnt);
                    chk(limit_hit == e.hit, t, "limit_hit at done", limit_hit, e.hit);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(ctx_valid == 1'b0 && xfer_valid == 1'b0 && done == 1'b0, "R1", "valids in reset",
            {ctx_valid, xfer_valid, done}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(ctx_valid == 1'b0 && xfer_valid == 1'b0 && done == 1'b0, "R1", "valids after reset",
            {ctx_valid, xfer_valid, done}, 0);
        chk(err_sum == 16'd0, "R1", "err_sum after reset", err_sum, 0);
        chk(xfer_count == 9'd0 && limit_hit == 1'b0, "R1", "count/hit after reset",
            {xfer_count, limit_hit}, 0);

        // R2 R5 R10: formula predictor, no transfers possible, gapped stream
        pmode = 0;
        for (int i = 0; i < 256; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            img[i] = seed[23:16];
        end
        thr_vec = '1;
        xfer_limit = 9'd256;
        send_tile("R2 R5 R10", 1'b1, 1'b1);

        // R6 R7: distinct quadrant thresholds
        for (int i = 0; i < 256; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            img[i] = seed[23:16];
        end
        thr_vec = {8'd200, 8'd90, 8'd40, 8'd10};
        send_tile("R6 R7", 1'b0, 1'b1);

        // R8: errors exactly at and one above each quadrant threshold
        pmode = 1;
        pconst = 8'd100;
        thr_vec = {8'd60, 8'd33, 8'd17, 8'd5};
        for (int i = 0; i < 256; i++) begin
            int q;
            q = ((i / 16) >= 8 ? 2 : 0) + ((i % 16) >= 8 ? 1 : 0);
            img[i] = 8'd100 + thr_vec[q*8 +: 8] + 8'(i % 2);
        end
        send_tile("R6 R8", 1'b0, 1'b1);

        // R9 then R4: budget runs out, next tile back to back restarts totals
        pconst = 8'd0;
        thr_vec = '0;
        xfer_limit = 9'd3;
        for (int i = 0; i < 256; i++) img[i] = 8'd200;
        send_tile("R9", 1'b0, 1'b0);
        for (int i = 0; i < 256; i++) img[i] = 8'd0;
        img[17]  = 8'd5;
        img[255] = 8'd9;
        send_tile("R4 R9", 1'b0, 1'b1);

        // R11: largest possible tile error
        thr_vec = '1;
        xfer_limit = 9'd0;
        for (int i = 0; i < 256; i++) img[i] = 8'd255;
        send_tile("R11", 1'b1, 1'b1);

        chk(ctxq.size() == 0 && xq.size() == 0 && resq.size() == 0, "R10",
            "all expected items seen", ctxq.size() + xq.size() + resq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule